// File: doc/BRIEF.md
# Flash Chip-Select Segment Window Decoder

This block keeps one window register per flash chip select. Each window is a contiguous slice of the controller's flash address range, expressed in 8 MB units. Software programs the windows through a small register port. Every update is screened before it is stored. The start of chip select 0 is pinned to the base of the flash range. An update that lands wholly outside the range is refused. Misaligned and overlapping windows are still stored, but they are reported.

On the host side, each valid address is resolved to a chip-select index and a byte offset inside that chip select's window. The result is registered. An address that no window claims is reported as a miss. Four sticky error bits record refused updates, misalignment, overlaps and stray accesses. Software clears them by writing ones.

Top module: `flash_seg_decoder`

## Requirements
- R1: A window register holds the end field in bits [31:24] and the start field in bits [23:16], both in 8 MB units (address bit 23 upward). Bits [15:0] always read as zero, whatever value was written there.
- R2: After reset, chip select 0 holds 0x4840_0000 (64 MB at the range base, unit 0x40). Chip selects 1 to 4 hold 0x4C48_0000, 0x504C_0000, 0x5450_0000 and 0x5854_0000. The status register reads zero and `dec_valid` is low.
- R3: A write to chip select 0 always stores the start field as 0x40, whatever start value was written.
- R4: A write whose end field is at or below 0x40, or whose start field is above 0x60 (the top of the 256 MB range), is refused. The old value is kept and status bit 0 is set.
- R5: A stored window whose length L = end - start is nonzero, and whose start field has any bit set in (L - 1), sets status bit 1. The value is still stored.
- R6: A stored window that shares at least one unit with another nonempty window sets status bit 2. The value is still stored.
- R7: A write equal to the value already held changes nothing: the register and the status bits stay as they were.
- R8: One cycle after `acc_valid`, `dec_valid` is high. A window with end > start claims addresses whose bits [31:23] lie in [start, end), and a window with end <= start claims nothing. On a hit, `dec_cs` gives the index and `dec_offset` gives the address minus start × 8 MB.
- R9: When several windows claim an address, the lowest chip-select index is reported.
- R10: An address that no window claims gives `dec_hit` = 0, `dec_cs` = 0 and `dec_offset` = 0, and sets status bit 3.
- R11: The status register is at register index 5, with bits [3:0] mirrored on `err_flags`. Its bits stay set until a write of one to that bit clears them. A bit that is set and cleared in the same cycle ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index: 0-4 are windows, 5 is status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read of the register at `reg_idx` |
| acc_valid | input | 1 | Host address valid |
| acc_addr | input | 32 | Host address |
| dec_valid | output | 1 | Decode result valid |
| dec_hit | output | 1 | Address claimed by a window |
| dec_cs | output | 3 | Selected chip-select index |
| dec_offset | output | 32 | Byte offset within the selected window |
| err_flags | output | 4 | Sticky flags: refused, misaligned, overlap, stray |

## Verification
A register write is taken on a rising edge. The stored value on `reg_rdata` and the new status bits are both due one edge later. A decode result and its stray flag are due on the edge after `acc_valid` is sampled.

The bench drives all inputs on falling edges and samples on the next falling edge, half a period after the edge that registered the result. A reference model in the bench is updated at that same point, so expected and actual values describe the same edge.

// File: rtl/flash_seg_pkg.sv
// Shared types and helpers for the flash segment window decoder.
// Assumes 8-bit unit fields inside 32-bit window registers.
package flash_seg_pkg;
    localparam int UNIT_W    = 8;
    localparam int NUM_FLAGS = 4;
    localparam int FLG_RANGE   = 0;
    localparam int FLG_ALIGN   = 1;
    localparam int FLG_OVERLAP = 2;
    localparam int FLG_STRAY   = 3;

    typedef logic [UNIT_W-1:0] unit_t;

    // Window length in units; an inverted or equal pair is an empty window.
    function automatic unit_t win_len(input unit_t s, input unit_t e);
        return (e > s) ? unit_t'(e - s) : '0;
    endfunction
endpackage

// File: rtl/flash_seg_check.sv
// Screens a candidate window write against the flash range and the other
// windows. It is purely combinational. It assumes NUM_CS >= 2 and that
// idx is a valid window index.
module flash_seg_check
    import flash_seg_pkg::*;
#(
    parameter int          NUM_CS     = 5,
    parameter int          CS_W       = 3,
    parameter logic [7:0]  WIN_BASE_U = 8'h40,
    parameter logic [8:0]  WIN_TOP_U  = 9'h060
) (
    input  logic [CS_W-1:0]               idx,
    input  unit_t                         wr_s,
    input  unit_t                         wr_e,
    input  logic [NUM_CS-1:0][UNIT_W-1:0] cur_s,
    input  logic [NUM_CS-1:0][UNIT_W-1:0] cur_e,
    output unit_t                         cand_s,
    output logic                          refuse,
    output logic                          misalign,
    output logic                          overlap
);
    unit_t             new_len;
    logic [NUM_CS-1:0] ov_vec;

    // Pin chip select 0 to the range base, then size the candidate.
    always_comb begin
        cand_s   = (idx == '0) ? WIN_BASE_U : wr_s;
        new_len  = win_len(cand_s, wr_e);
        refuse   = (wr_e <= WIN_BASE_U) || ({1'b0, cand_s} > WIN_TOP_U);
        misalign = (new_len != '0) && ((cand_s & unit_t'(new_len - 8'd1)) != '0);
    end

    // One overlap comparator per other window.
    for (genvar j = 0; j < NUM_CS; j++) begin : g_ov
        unit_t o_len;
        assign o_len     = win_len(cur_s[j], cur_e[j]);
        assign ov_vec[j] = (CS_W'(j) != idx) && (new_len != '0) && (o_len != '0)
                           && (cand_s < cur_e[j]) && (wr_e > cur_s[j]);
    end

    assign overlap = |ov_vec;
endmodule

// File: rtl/flash_seg_match.sv
// Resolves a host address to the lowest-numbered window that claims it and
// registers the index, offset and hit. A claim needs a nonempty window.
// Assumes ADDR_W - UNIT_SHIFT >= 8.
module flash_seg_match
    import flash_seg_pkg::*;
#(
    parameter int NUM_CS     = 5,
    parameter int CS_W       = 3,
    parameter int ADDR_W     = 32,
    parameter int UNIT_SHIFT = 23
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          acc_valid,
    input  logic [ADDR_W-1:0]             acc_addr,
    input  logic [NUM_CS-1:0][UNIT_W-1:0] cur_s,
    input  logic [NUM_CS-1:0][UNIT_W-1:0] cur_e,
    output logic                          dec_valid,
    output logic                          dec_hit,
    output logic [CS_W-1:0]               dec_cs,
    output logic [ADDR_W-1:0]             dec_offset,
    output logic                          stray
);
    localparam int AU_W = ADDR_W - UNIT_SHIFT;

    logic [AU_W-1:0]   addr_u;
    logic [NUM_CS-1:0] hit_vec;
    logic [NUM_CS-1:0] lower_hits;
    logic [CS_W-1:0]   cur_sel;
    unit_t             len_a [NUM_CS];

    assign addr_u = acc_addr[ADDR_W-1:UNIT_SHIFT];

    // Per-window range comparators.
    for (genvar g = 0; g < NUM_CS; g++) begin : g_cmp
        assign len_a[g]   = win_len(cur_s[g], cur_e[g]);
        assign hit_vec[g] = (len_a[g] != '0) && (addr_u >= AU_W'(cur_s[g]))
                            && (addr_u < AU_W'(cur_e[g]));
    end

    // Priority pick: the lowest claiming index wins.
    always_comb begin
        cur_sel = '0;
        for (int i = NUM_CS - 1; i >= 0; i--) begin
            if (hit_vec[i]) cur_sel = CS_W'(i);
        end
    end

    assign lower_hits = hit_vec & ((NUM_CS'(1) << cur_sel) - NUM_CS'(1));
    assign stray      = acc_valid && (hit_vec == '0);

    // Register the decode result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid  <= 1'b0;
            dec_hit    <= 1'b0;
            dec_cs     <= '0;
            dec_offset <= '0;
        end else begin
            dec_valid <= acc_valid;
            if (acc_valid && (hit_vec != '0)) begin
                dec_hit    <= 1'b1;
                dec_cs     <= cur_sel;
                dec_offset <= acc_addr - (ADDR_W'(cur_s[cur_sel]) << UNIT_SHIFT);
            end else begin
                dec_hit    <= 1'b0;
                dec_cs     <= '0;
                dec_offset <= '0;
            end
        end
    end

    // R10: a miss leaves index and offset at zero.
    p_miss_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_hit) |-> (dec_cs == '0 && dec_offset == '0));

    // R8: a hit is reported only for a valid request.
    p_hit_needs_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dec_hit |-> dec_valid);

    // R8: the reported offset lies inside the selected window.
    p_offset_inside_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && hit_vec != '0) |=>
            ((dec_offset >> UNIT_SHIFT) < ADDR_W'($past(len_a[cur_sel]))));

    // R9: no lower-numbered window claimed the reported address.
    p_lowest_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && hit_vec != '0) |=> ($past(lower_hits) == '0));
endmodule

// File: rtl/flash_seg_flags.sv
// Sticky error bits with write-one-to-clear. A set in the same cycle as a
// clear takes precedence.
module flash_seg_flags #(
    parameter int FLAG_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] set,
    input  logic [FLAG_W-1:0] clr,
    output logic [FLAG_W-1:0] flags
);
    // Hold, clear and set the sticky bits.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr) | set;
    end

    // R11: a set bit that is not cleared stays set.
    p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags & $past(flags & ~clr)) == $past(flags & ~clr)));

    // R11: a set always lands, even against a clear.
    p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (set != '0) |=> ((flags & $past(set)) == $past(set)));
endmodule

// File: rtl/flash_seg_decoder.sv
// Top of the flash segment window decoder. It holds one window register per
// chip select, screens updates to them, decodes host addresses and keeps the
// sticky status bits. Register index NUM_CS is the status register.
// Assumes NUM_CS >= 2 and that the range top fits in 9 unit bits.
module flash_seg_decoder
    import flash_seg_pkg::*;
#(
    parameter int         NUM_CS      = 5,
    parameter int         ADDR_W      = 32,
    parameter int         UNIT_SHIFT  = 23,
    parameter logic [7:0] WIN_BASE_U  = 8'h40,
    parameter logic [7:0] WIN_SIZE_U  = 8'h20,
    parameter int         DEF_SIZE0_U = 8,
    parameter int         DEF_SIZE_U  = 4,
    localparam int        CS_W        = $clog2(NUM_CS),
    localparam int        IDX_W       = $clog2(NUM_CS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              dec_valid,
    output logic              dec_hit,
    output logic [CS_W-1:0]   dec_cs,
    output logic [ADDR_W-1:0] dec_offset,
    output logic [3:0]        err_flags
);
    localparam logic [8:0] WIN_TOP_U = {1'b0, WIN_BASE_U} + {1'b0, WIN_SIZE_U};
    localparam int         STAT_IDX  = NUM_CS;

    logic [NUM_CS-1:0][UNIT_W-1:0] seg_s;
    logic [NUM_CS-1:0][UNIT_W-1:0] seg_e;
    logic                          wr_is_seg;
    logic [CS_W-1:0]               chk_idx;
    logic                          same_val;
    logic                          seg_wr;
    unit_t                         cand_s;
    logic                          chk_refuse, chk_misalign, chk_overlap;
    logic                          stray;
    logic [NUM_FLAGS-1:0]          flag_set, flag_clr, flags;

    // Reset default for a window: a large first window, then equal steps.
    function automatic logic [15:0] def_win(input int i);
        int s, e;
        if (i == 0) begin
            s = int'(WIN_BASE_U);
            e = s + DEF_SIZE0_U;
        end else begin
            s = int'(WIN_BASE_U) + DEF_SIZE0_U + (i - 1) * DEF_SIZE_U;
            e = s + DEF_SIZE_U;
        end
        return {unit_t'(e), unit_t'(s)};
    endfunction

    // Decode the register port access.
    always_comb begin
        wr_is_seg = (int'(reg_idx) < NUM_CS);
        chk_idx   = wr_is_seg ? CS_W'(reg_idx) : '0;
        same_val  = (reg_wdata == {seg_e[chk_idx], seg_s[chk_idx], 16'h0000});
        seg_wr    = reg_we && wr_is_seg && !same_val;
    end

    flash_seg_check #(
        .NUM_CS(NUM_CS), .CS_W(CS_W), .WIN_BASE_U(WIN_BASE_U), .WIN_TOP_U(WIN_TOP_U)
    ) u_check (
        .idx(chk_idx), .wr_s(reg_wdata[23:16]), .wr_e(reg_wdata[31:24]),
        .cur_s(seg_s), .cur_e(seg_e), .cand_s(cand_s),
        .refuse(chk_refuse), .misalign(chk_misalign), .overlap(chk_overlap)
    );

    // Hold the window registers; store screened writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CS; i++) begin
                {seg_e[i], seg_s[i]} <= def_win(i);
            end
        end else if (seg_wr && !chk_refuse) begin
            seg_s[chk_idx] <= cand_s;
            seg_e[chk_idx] <= reg_wdata[31:24];
        end
    end

    flash_seg_match #(
        .NUM_CS(NUM_CS), .CS_W(CS_W), .ADDR_W(ADDR_W), .UNIT_SHIFT(UNIT_SHIFT)
    ) u_match (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .cur_s(seg_s), .cur_e(seg_e), .dec_valid(dec_valid), .dec_hit(dec_hit),
        .dec_cs(dec_cs), .dec_offset(dec_offset), .stray(stray)
    );

    // Gather flag set and clear requests.
    always_comb begin
        flag_set              = '0;
        flag_set[FLG_RANGE]   = seg_wr && chk_refuse;
        flag_set[FLG_ALIGN]   = seg_wr && !chk_refuse && chk_misalign;
        flag_set[FLG_OVERLAP] = seg_wr && !chk_refuse && chk_overlap;
        flag_set[FLG_STRAY]   = stray;
        flag_clr = (reg_we && int'(reg_idx) == STAT_IDX) ? reg_wdata[NUM_FLAGS-1:0] : '0;
    end

    flash_seg_flags #(.FLAG_W(NUM_FLAGS)) u_flags (
        .clk(clk), .rst_n(rst_n), .set(flag_set), .clr(flag_clr), .flags(flags)
    );

    assign err_flags = flags;

    // Read mux over windows and status.
    always_comb begin
        if (wr_is_seg)                    reg_rdata = {seg_e[chk_idx], seg_s[chk_idx], 16'h0000};
        else if (int'(reg_idx) == STAT_IDX) reg_rdata = 32'(flags);
        else                              reg_rdata = '0;
    end

    // R3: chip select 0 always starts at the range base.
    p_cs0_pinned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        seg_s[0] == WIN_BASE_U);

    // R4: every stored window touches the flash range.
    for (genvar g = 0; g < NUM_CS; g++) begin : g_win_props
        p_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (seg_e[g] > WIN_BASE_U) && ({1'b0, seg_s[g]} <= WIN_TOP_U));
    end

    // R4: a refused write leaves all windows untouched.
    p_refuse_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_wr && chk_refuse) |=> ($stable(seg_s) && $stable(seg_e)));

    // R7: rewriting the held value changes no window and no flag.
    p_same_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && wr_is_seg && same_val && !acc_valid) |=>
            ($stable(seg_s) && $stable(seg_e) && $stable(flags)));
endmodule

// File: tb/flash_seg_decoder_tb.sv
`timescale 1ns/1ps
module flash_seg_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        dec_valid, dec_hit;
    logic [2:0]  dec_cs;
    logic [31:0] dec_offset;
    logic [3:0]  err_flags;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    logic [31:0] m_seg [5];
    logic [3:0]  m_flags;

    always #10 clk = ~clk;

    flash_seg_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
        .acc_addr(acc_addr), .dec_valid(dec_valid), .dec_hit(dec_hit),
        .dec_cs(dec_cs), .dec_offset(dec_offset), .err_flags(err_flags)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] m_len(input logic [7:0] s, input logic [7:0] e);
        return (e > s) ? 8'(e - s) : 8'h00;
    endfunction

    // Reference model of a register write (R1, R3-R7, R11).
    function automatic void m_write(input int idx, input logic [31:0] v);
        logic [7:0] s, e, l;
        if (idx == 5) begin
            m_flags &= ~v[3:0];
        end else if (idx < 5 && v != m_seg[idx]) begin
            s = (idx == 0) ? 8'h40 : v[23:16];
            e = v[31:24];
            if (e <= 8'h40 || s > 8'h60) m_flags |= 4'b0001;
            else begin
                l = m_len(s, e);
                if (l != 0 && (s & (l - 8'd1)) != 0) m_flags |= 4'b0010;
                for (int j = 0; j < 5; j++) begin
                    if (j != idx && l != 0 && m_len(m_seg[j][23:16], m_seg[j][31:24]) != 0
                        && s < m_seg[j][31:24] && e > m_seg[j][23:16])
                        m_flags |= 4'b0100;
                end
                m_seg[idx] = {e, s, 16'h0};
            end
        end
    endfunction

    // Reference decode (R8-R10): returns {hit, cs, offset}.
    function automatic logic [35:0] m_decode(input logic [31:0] a);
        logic [8:0] u;
        u = a[31:23];
        for (int i = 0; i < 5; i++) begin
            if (m_len(m_seg[i][23:16], m_seg[i][31:24]) != 0
                && u >= {1'b0, m_seg[i][23:16]} && u < {1'b0, m_seg[i][31:24]})
                return {1'b1, 3'(i), a - ({24'h0, m_seg[i][23:16]} << 23)};
        end
        return 36'h0;
    endfunction

    task automatic check_status(input string tag);
        reg_idx = 3'd5;
        #1;
        chk({tag, " status"}, reg_rdata, {28'h0, m_flags});
        chk({tag, " err_flags"}, {28'h0, err_flags}, {28'h0, m_flags});
    endtask

    task automatic do_write(input int idx, input logic [31:0] v, input string tag);
        @(negedge clk);
        reg_we = 1'b1; reg_idx = 3'(idx); reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
        m_write(idx, v);
        if (idx < 5) begin
            reg_idx = 3'(idx);
            #1;
            chk({tag, " window"}, reg_rdata, m_seg[idx]);
        end
        check_status(tag);
    endtask

    task automatic do_access(input logic [31:0] a, input string tag);
        logic [35:0] exp;
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a;
        @(negedge clk);
        acc_valid = 1'b0;
        exp = m_decode(a);
        if (!exp[35]) m_flags |= 4'b1000;
        chk({tag, " valid"}, {31'h0, dec_valid}, 32'h1);
        chk({tag, " hit"}, {31'h0, dec_hit}, {31'h0, exp[35]});
        chk({tag, " cs"}, {29'h0, dec_cs}, {29'h0, exp[34:32]});
        chk({tag, " offset"}, dec_offset, exp[31:0]);
        check_status(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        m_seg[0] = 32'h4840_0000; m_seg[1] = 32'h4C48_0000; m_seg[2] = 32'h504C_0000;
        m_seg[3] = 32'h5450_0000; m_seg[4] = 32'h5854_0000;
        m_flags = 4'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: reset state
        for (int i = 0; i < 5; i++) begin
            reg_idx = 3'(i);
            #1;
            chk("R2 reset window", reg_rdata, m_seg[i]);
        end
        chk("R2 reset dec_valid", {31'h0, dec_valid}, 32'h0);
        check_status("R2 reset");

        // R3 and R6: moving CS0 start is corrected; the new window overlaps CS1
        do_write(0, 32'h5030_0000, "R3 cs0 pinned / R6 overlap");
        do_write(5, 32'hF, "R11 clear all");
        // R4: end at base refused; start beyond top refused
        do_write(2, 32'h4030_0000, "R4 end at base");
        do_write(2, 32'h6261_0000, "R4 start past top");
        do_write(5, 32'h1, "R11 clear bit0");
        // R5: misaligned window is stored and flagged
        do_write(3, 32'h5351_0000, "R5 misaligned");
        do_write(5, 32'hF, "R11 clear");
        // R7: same value write is ignored
        do_write(3, 32'h5351_0000, "R7 same value");
        // R1: low bits dropped
        do_write(4, 32'h5C58_ABCD, "R1 low bits");
        // R8: decode in CS0, then CS4
        do_access(32'h2010_0000, "R8 cs0 decode");
        do_access(32'h2C12_3456, "R8 cs4 decode");
        // R9: CS0 (0x40-0x50) covers CS1 (0x48-0x4C); CS0 wins
        do_access(32'h2480_0010, "R9 lowest wins");
        // R10: miss below range
        do_access(32'h1000_0000, "R10 miss");
        // R8: empty window never claims
        do_write(5, 32'hF, "R11 clear");
        do_write(4, 32'h5858_0000, "R8 empty window write");
        do_access(32'h2C00_0000, "R8 empty window access");
        // R11: set in the same cycle as clear leaves the bit set
        @(negedge clk);
        reg_we = 1'b1; reg_idx = 3'd5; reg_wdata = 32'h8;
        acc_valid = 1'b1; acc_addr = 32'h0800_0000;
        @(negedge clk);
        reg_we = 1'b0; acc_valid = 1'b0;
        m_flags = (m_flags & ~4'h8) | 4'h8;
        check_status("R11 set beats clear");

        // Constrained random mix
        for (int it = 0; it < 400; it++) begin
            int op;
            op = int'($urandom_range(0, 9));
            if (op < 4) begin
                int idx;
                logic [7:0] s, e;
                idx = int'($urandom_range(0, 4));
                s = 8'(8'h38 + $urandom_range(0, 48));
                e = 8'(8'h38 + $urandom_range(0, 48));
                if ($urandom_range(0, 7) == 0) do_write(idx, m_seg[idx], "R7 random same");
                else do_write(idx, {e, s, 8'(m_seg[0][7:0]), 8'($urandom_range(0, 3))}, "R4 R5 R6 random write");
            end else if (op == 4) begin
                do_write(5, 32'($urandom_range(0, 15)), "R11 random clear");
            end else begin
                logic [8:0] u;
                u = 9'($urandom_range(9'h38, 9'h68));
                do_access({u, 23'($urandom)}, "R8 R9 R10 random access");
            end
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule